// File: doc/BRIEF.md
# Flash Program/Erase Status Engine

This block executes byte-program, whole-array erase and boot-lock commands that an upstream command decoder has already recognised and handed over as single-cycle strobes. It holds a behavioural model of a byte-wide non-volatile array. An internal cycle timer stands in for the slow internal program and erase pulses, and each duration is a parameterised number of clock cycles. For the whole length of an operation, the block holds its ready output low. This output models an open-drain ready/busy line, so a low level means busy.

Programming can only clear bits: the stored byte becomes the old byte ANDed with the new byte, and only erase brings bits back to 1. A small boot region is at the bottom or the top of the address space, chosen by a parameter. Once the sticky lock flag is set, this region refuses programming and survives erase, unless the high-voltage override input is held when the command arrives.

While an operation runs, a read returns a status byte instead of array data. The top bit is the complement of the top bit being programmed. The next bit alternates from one read to the next. Host software can therefore poll for completion without watching the ready line.

Top module: `flash_status_engine`

## Requirements
- R1: A completed program leaves the addressed byte equal to its previous value ANDed with the command data, so a program never turns a 0 bit into a 1.
- R2: A completed erase sets every byte to all ones. The only exception is the boot region: when the lock flag is set and the override input was low at command time, the boot region keeps its contents.
- R3: With the lock set and the override low, a program strobe to a boot-region address is refused. No busy period starts and the byte is unchanged. With TOP_BOOT=1 the boot region is the highest 2^BOOT_W addresses, and with TOP_BOOT=0 it is the lowest 2^BOOT_W addresses. Addresses just outside the region are programmed normally.
- R4: A lock command keeps `rdy_o` low for LOCK_CYC cycles and then sets the lock flag. Once set, the flag never clears, not even through `rst_n`.
- R5: When the override input is high as a program or erase strobe is accepted, the boot region is programmed or erased despite the lock. Once the override is low again, protection applies again.
- R6: While busy, a read returns a status byte in which bits 5..0 are zero. During a program, bit 7 is the inverse of bit 7 of the data being programmed. During an erase or a lock, bit 7 is 0.
- R7: While busy, bit 6 of the status byte is 1 on the first read after the command is accepted and alternates on each later read. After completion, reads return true array data, which does not alternate.
- R8: `rdy_o` goes low in the cycle after a command is accepted. It stays low for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase, and then returns high.
- R9: Command strobes that arrive while busy are ignored. They do not lengthen the running operation and do not touch the array.
- R10: While `rst_n` is low, the running operation is aborted and the array is left as it was. `rd_oe_o` is low, `rdy_o` is high and `rd_data_o` is 0. After release, `rd_oe_o` rises at the first clock edge, and an aborted program must be issued again to take effect.
- R11: `rd_data_o` takes the result of a read at the clock edge where `rd_stb_i` is sampled high, and it holds that value otherwise.
- R12: When several command strobes are high in the same idle cycle, only the program strobe is considered. The erase and lock strobes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; aborts the running operation |
| hv_override_i | input | 1 | High-voltage override; lifts boot-region protection while held |
| prog_stb_i | input | 1 | Byte program command strobe |
| erase_stb_i | input | 1 | Whole-array erase command strobe |
| lock_stb_i | input | 1 | Boot-lock command strobe |
| cmd_addr_i | input | ADDR_W | Program address |
| cmd_data_i | input | DATA_W | Program data |
| rd_stb_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read result: array data when idle, status byte when busy |
| rd_oe_o | output | 1 | Output enable; low while in reset |
| rdy_o | output | 1 | Ready (high) / busy (low) |

## Verification
The bench builds the block with ADDR_W=8, BOOT_W=4, TOP_BOOT=1, PROG_CYC=5, ERASE_CYC=20 and LOCK_CYC=3. With these values the boot region is addresses F0..FF, the unprotected neighbour is EF, and every busy window is short enough to count cycle by cycle. A five-cycle program leaves room for three status polls followed by a measured remainder. The whole lock, erase, reset and override sequence fits in a few hundred cycles.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_LOCK  = 2'd3
    } flash_op_e;

endpackage

// File: rtl/flash_boot_guard.sv
// Decides whether a program address falls inside the protected boot region.
module flash_boot_guard #(
    parameter int ADDR_W   = 10,
    parameter int BOOT_W   = 6,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [ADDR_W-BOOT_W-1:0] addr_hi_i,
    input  logic                     lock_i,
    input  logic                     override_i,
    output logic                     block_o
);

    logic in_boot;

    generate
        if (TOP_BOOT) begin : g_top
            assign in_boot = &addr_hi_i;
        end else begin : g_bottom
            assign in_boot = ~|addr_hi_i;
        end
    endgenerate

    assign block_o = in_boot & lock_i & ~override_i;

endmodule

// File: rtl/flash_cycle_timer.sv
// Down-counter shared by every operation; last_o marks the final busy cycle.
module flash_cycle_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = len_i - CNT_W'(1);
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign last_o = (tmr_q.cnt == '0);

endmodule

// File: rtl/flash_nv_array.sv
// Behavioural non-volatile store: byte array plus sticky boot-lock bit.
// Neither is cleared by reset; the lock starts clear as a factory state.
module flash_nv_array #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter int BOOT_W   = 6,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              prog_en_i,
    input  logic [ADDR_W-1:0] prog_addr_i,
    input  logic [DATA_W-1:0] prog_data_i,
    input  logic              erase_en_i,
    input  logic              erase_keep_boot_i,
    input  logic              lock_set_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              lock_o
);

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int BOOT_SEL = TOP_BOOT ? ((1 << (ADDR_W - BOOT_W)) - 1) : 0;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              lock_q = 1'b0;

    always_ff @(posedge clk) begin
        if (prog_en_i) begin
            mem[prog_addr_i] <= mem[prog_addr_i] & prog_data_i;
        end
        if (erase_en_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!(erase_keep_boot_i && ((i >> BOOT_W) == BOOT_SEL))) begin
                    mem[ADDR_W'(i)] <= '1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        lock_q <= lock_q | lock_set_i;
    end

    assign rd_data_o = mem[rd_addr_i];
    assign lock_o    = lock_q;

    // R4
    lock_sticky_chk: assert property (@(posedge clk) lock_q |=> lock_q);

    // R12
    one_commit_chk: assert property (@(posedge clk) !(prog_en_i && erase_en_i));

endmodule

// File: rtl/flash_status_engine.sv
module flash_status_engine
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int BOOT_W    = 6,
    parameter bit TOP_BOOT  = 1'b1,
    parameter int PROG_CYC  = 30,
    parameter int ERASE_CYC = 3000,
    parameter int LOCK_CYC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_override_i,
    input  logic              prog_stb_i,
    input  logic              erase_stb_i,
    input  logic              lock_stb_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_oe_o,
    output logic              rdy_o
);

    localparam int MAX_PE  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_CYC = (MAX_PE > LOCK_CYC) ? MAX_PE : LOCK_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int POL_BIT = DATA_W - 1;
    localparam int TOG_BIT = DATA_W - 2;

    typedef struct packed {
        flash_op_e         op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              keep_boot;
        logic              tog;
        logic [DATA_W-1:0] rd_data;
        logic              oe;
    } eng_t;

    eng_t st_d, st_q;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    logic              tmr_last;
    logic              prog_en;
    logic              erase_en;
    logic              lock_set;
    logic              arr_lock;
    logic [DATA_W-1:0] arr_rd_data;
    logic              guard_block;
    logic              busy;
    logic [DATA_W-1:0] status;

    flash_boot_guard #(
        .ADDR_W   (ADDR_W),
        .BOOT_W   (BOOT_W),
        .TOP_BOOT (TOP_BOOT)
    ) u_guard (
        .addr_hi_i  (cmd_addr_i[ADDR_W-1:BOOT_W]),
        .lock_i     (arr_lock),
        .override_i (hv_override_i),
        .block_o    (guard_block)
    );

    flash_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .last_o (tmr_last)
    );

    flash_nv_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BOOT_W   (BOOT_W),
        .TOP_BOOT (TOP_BOOT)
    ) u_array (
        .clk               (clk),
        .prog_en_i         (prog_en),
        .prog_addr_i       (st_q.addr),
        .prog_data_i       (st_q.data),
        .erase_en_i        (erase_en),
        .erase_keep_boot_i (st_q.keep_boot),
        .lock_set_i        (lock_set),
        .rd_addr_i         (rd_addr_i),
        .rd_data_o         (arr_rd_data),
        .lock_o            (arr_lock)
    );

    assign busy = (st_q.op != OP_IDLE);

    always_comb begin
        st_d     = st_q;
        st_d.oe  = 1'b1;
        tmr_load = 1'b0;
        tmr_len  = '0;
        prog_en  = 1'b0;
        erase_en = 1'b0;
        lock_set = 1'b0;

        // command acceptance and completion
        if (!busy) begin
            if (prog_stb_i) begin
                if (!guard_block) begin
                    st_d.op   = OP_PROG;
                    st_d.addr = cmd_addr_i;
                    st_d.data = cmd_data_i;
                    st_d.tog  = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_len   = CNT_W'(PROG_CYC);
                end
            end else if (erase_stb_i) begin
                st_d.op        = OP_ERASE;
                st_d.keep_boot = arr_lock & ~hv_override_i;
                st_d.tog       = 1'b0;
                tmr_load       = 1'b1;
                tmr_len        = CNT_W'(ERASE_CYC);
            end else if (lock_stb_i) begin
                st_d.op  = OP_LOCK;
                st_d.tog = 1'b0;
                tmr_load = 1'b1;
                tmr_len  = CNT_W'(LOCK_CYC);
            end
        end else if (tmr_last) begin
            unique case (st_q.op)
                OP_PROG:  prog_en  = 1'b1;
                OP_ERASE: erase_en = 1'b1;
                OP_LOCK:  lock_set = 1'b1;
                default:  ;
            endcase
            st_d.op = OP_IDLE;
        end

        // read path: status byte while busy, array data otherwise
        status          = '0;
        status[POL_BIT] = (st_q.op == OP_PROG) ? ~st_q.data[POL_BIT] : 1'b0;
        status[TOG_BIT] = ~st_q.tog;
        if (rd_stb_i) begin
            if (busy) begin
                st_d.rd_data = status;
                st_d.tog     = ~st_q.tog;
            end else begin
                st_d.rd_data = arr_rd_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{op: OP_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rd_data;
    assign rd_oe_o   = st_q.oe;
    assign rdy_o     = ~busy;

    // R3
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_stb_i && rdy_o && guard_block) |=> rdy_o);

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_stb_i && rdy_o && !guard_block) |=> !rdy_o);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> $past(tmr_last));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_o && (prog_stb_i || erase_stb_i || lock_stb_i))
        |=> ($stable(st_q.addr) && $stable(st_q.data)));

endmodule

// File: tb/flash_status_engine_tb.sv
module flash_status_engine_tb;

    localparam int CLK_P     = 10;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int PROG_CYC  = 5;
    localparam int ERASE_CYC = 20;
    localparam int LOCK_CYC  = 3;
    localparam int NVEC      = 8;

    // {address, program data, expected byte after program}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h10_A5_A5, 24'h10_3C_24, 24'h10_FF_24, 24'h20_00_00,
        24'h7F_F0_F0, 24'h7F_0F_00, 24'hEF_81_81, 24'hF5_77_77
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hv = 1'b0;
    logic              prog_stb = 1'b0;
    logic              erase_stb = 1'b0;
    logic              lock_stb = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic              rd_stb = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_oe;
    logic              rdy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    flash_status_engine #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BOOT_W    (4),
        .TOP_BOOT  (1'b1),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC),
        .LOCK_CYC  (LOCK_CYC)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .hv_override_i (hv),
        .prog_stb_i    (prog_stb),
        .erase_stb_i   (erase_stb),
        .lock_stb_i    (lock_stb),
        .cmd_addr_i    (cmd_addr),
        .cmd_data_i    (cmd_data),
        .rd_stb_i      (rd_stb),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .rd_oe_o       (rd_oe),
        .rdy_o         (rdy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe(input bit p, input bit e, input bit l,
                          input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        prog_stb = p; erase_stb = e; lock_stb = l;
        cmd_addr = a; cmd_data = d;
        step();
        prog_stb = 1'b0; erase_stb = 1'b0; lock_stb = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!rdy && n < 1000) begin
            step();
            n++;
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        rd_stb = 1'b1; rd_addr = a;
        step();
        rd_stb = 1'b0;
        v = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [DATA_W-1:0] v;

        // reset state (R10)
        repeat (3) @(posedge clk);
        #1;
        check("R10 oe low in reset", rd_oe, 0);
        check("R10 ready in reset", rdy, 1);
        check("R10 data zero in reset", rd_data, 0);
        rst_n = 1'b1;
        step();
        check("R10 oe after release", rd_oe, 1);

        // first erase (R2, R8)
        strobe(0, 1, 0, 0, 0);
        wait_ready(n);
        check("R8 erase busy length", n, ERASE_CYC);
        rd(8'h00, v); check("R2 erase low byte", v, 8'hFF);
        rd(8'hFF, v); check("R2 erase top byte", v, 8'hFF);

        // vector table: AND programming (R1, R8)
        for (int i = 0; i < NVEC; i++) begin
            strobe(1, 0, 0, VEC[i][23:16], VEC[i][15:8]);
            wait_ready(n);
            check("R8 program busy length", n, PROG_CYC);
            rd(VEC[i][23:16], v);
            check("R1 program result", v, VEC[i][7:0]);
        end

        // status polling during program (R6, R7, R11)
        strobe(1, 0, 0, 8'h30, 8'h12);
        rd(8'h30, v); check("R7 first poll", v, 8'hC0);
        rd(8'h30, v); check("R7 second poll", v, 8'h80);
        rd(8'h55, v); check("R6 poll any address", v, 8'hC0);
        step();
        check("R11 data held without strobe", rd_data, 8'hC0);
        wait_ready(n);
        check("R8 remaining busy", n, PROG_CYC - 4);
        rd(8'h30, v); check("R7 true data after done", v, 8'h12);
        rd(8'h30, v); check("R7 no toggle after done", v, 8'h12);
        strobe(1, 0, 0, 8'h31, 8'h85);
        rd(8'h31, v); check("R6 polarity bit for data bit7=1", v, 8'h40);
        wait_ready(n);
        rd(8'h31, v); check("R6 data after poll", v, 8'h85);

        // strobes while busy are ignored (R9)
        strobe(1, 0, 0, 8'h60, 8'h0F);
        strobe(1, 1, 1, 8'h61, 8'h00);
        wait_ready(n);
        check("R9 busy not extended", n, PROG_CYC - 1);
        rd(8'h61, v); check("R9 ignored program", v, 8'hFF);
        rd(8'h60, v); check("R9 running program done", v, 8'h0F);
        rd(8'h10, v); check("R9 ignored erase", v, 8'h24);

        // simultaneous strobes: program wins (R12)
        strobe(1, 1, 1, 8'h70, 8'h00);
        wait_ready(n);
        check("R12 program length", n, PROG_CYC);
        rd(8'h70, v); check("R12 program applied", v, 8'h00);
        rd(8'h10, v); check("R12 erase dropped", v, 8'h24);
        rd(8'hF5, v); check("R12 lock dropped, boot still writable", v, 8'h77);

        // reset abort (R10)
        strobe(1, 0, 0, 8'h50, 8'h00);
        step();
        rst_n = 1'b0;
        #1;
        check("R10 ready during abort", rdy, 1);
        check("R10 oe during abort", rd_oe, 0);
        step();
        rst_n = 1'b1;
        step();
        rd(8'h50, v); check("R10 aborted byte unchanged", v, 8'hFF);
        strobe(1, 0, 0, 8'h50, 8'h00);
        wait_ready(n);
        rd(8'h50, v); check("R10 repeated program", v, 8'h00);

        // lock (R4) and protection (R3)
        strobe(0, 0, 1, 0, 0);
        wait_ready(n);
        check("R4 lock busy length", n, LOCK_CYC);
        strobe(1, 0, 0, 8'hF5, 8'h00);
        check("R3 boot program refused", rdy, 1);
        rd(8'hF5, v); check("R3 boot byte kept", v, 8'h77);
        strobe(1, 0, 0, 8'hF0, 8'h00);
        check("R3 boot lowest address refused", rdy, 1);
        strobe(1, 0, 0, 8'hEF, 8'h01);
        wait_ready(n);
        check("R3 neighbour accepted", n, PROG_CYC);
        rd(8'hEF, v); check("R3 neighbour programmed", v, 8'h01);

        // erase with lock (R2, R6)
        strobe(0, 1, 0, 0, 0);
        rd(8'h10, v); check("R6 erase status", v, 8'h40);
        wait_ready(n);
        check("R8 erase remaining", n, ERASE_CYC - 1);
        rd(8'hF5, v); check("R2 boot kept when locked", v, 8'h77);
        rd(8'h10, v); check("R2 main erased", v, 8'hFF);
        rd(8'hEF, v); check("R2 neighbour erased", v, 8'hFF);

        // lock survives reset (R4)
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        strobe(1, 0, 0, 8'hF5, 8'h00);
        check("R4 lock after reset", rdy, 1);

        // override (R5)
        hv = 1'b1;
        strobe(1, 0, 0, 8'hF5, 8'h07);
        wait_ready(n);
        check("R5 override program length", n, PROG_CYC);
        rd(8'hF5, v); check("R5 override program", v, 8'h07);
        strobe(0, 1, 0, 0, 0);
        wait_ready(n);
        rd(8'hF5, v); check("R5 override erase", v, 8'hFF);
        hv = 1'b0;
        strobe(1, 0, 0, 8'hF5, 8'h00);
        check("R5 protection back", rdy, 1);
        rd(8'hF5, v); check("R5 byte unchanged", v, 8'hFF);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule